// File: doc/BRIEF.md
# Bit-Stream Transposition Unit

This block turns a group of eight input words into eight parallel bit streams. Each stream collects one bit position from every byte of the group. The same hardware also runs the inverse and rebuilds the eight byte-oriented words from eight bit streams. A word is W bits wide and holds W/8 bytes, so one group carries exactly W bytes and every output stream is W bits long.

The transform is done by inductive halving. The first stage splits bytes into high-nybble and low-nybble streams. The second stage splits nybbles into bit-pair streams. The third stage splits bit pairs into single bits. The inverse runs the mirrored sequence of interleaving merges: bits become bit pairs, bit pairs become nybbles, and nybbles become bytes.

Each stage is one register stage, so the block accepts one group per cycle. A direction flag is captured with each group and travels down the pipeline beside its data. Forward and inverse groups may therefore follow each other back to back.

Top module: `bst_transpose`

## Requirements
- R1: While rst_n is low, out_valid is 0 and out_words is all zeros.
- R2: out_valid is high exactly three clock cycles after a cycle in which in_valid is sampled high. A new group may be accepted on every cycle.
- R3: With in_inv = 0 (forward), bytes are numbered j = 0..W-1 across the group. Byte j sits in word j/(W/8), with its most significant bit at word bit W-1-8*(j mod W/8). Within a byte, bit index b counts from the most significant bit (b = 0 is byte bit 7). Output stream k holds bit k of byte j at stream bit W-1-j. Stream k is out_words[k] and word i is in_words[i].
- R4: With in_inv = 1 (inverse), in_words[k] is taken as stream k, and the output is the word group whose forward transform under R3 equals that input.
- R5: The direction is sampled together with in_valid for each group. Groups of either direction may be interleaved on consecutive cycles, and each group is transformed according to its own flag.
- R6: Feeding the forward output of a group back as an inverse group reproduces the original eight words bit for bit.
- R7: In a cycle where out_valid is 0, out_words keeps the value of the most recent valid result (all zeros if there has been none since reset).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A group is presented this cycle |
| in_inv | input | 1 | 0 = forward (bytes to streams), 1 = inverse (streams to bytes) |
| in_words | input | 8*W | Eight input words; in_words[i] is word or stream i |
| out_valid | output | 1 | A transformed group is on out_words |
| out_words | output | 8*W | Eight result words; out_words[k] is stream or word k |

## Verification
A wrong routing between halving stages scrambles bit positions. It shows up at the ports in the very group that exercises it, three cycles after input. Walking-one sweeps in both directions tie every input bit to exactly one output position. A direction tag that drifts from its data appears as a mis-transformed group in alternating traffic. A lost or extra valid, or a register that loads while idle, shows as a wrong out_valid or a changed out_words in the next idle output cycle.

// File: rtl/bst_pkg.sv
package bst_pkg;

    localparam int N_WORDS  = 8;
    localparam int N_LAYERS = 3;
    localparam int N_PAIRS  = N_WORDS / 2;

    // Field width split by a layer: 8 (bytes), 4 (nybbles), 2 (bit pairs)
    function automatic int layer_field(input int layer);
        return 8 >> layer;
    endfunction

    // Narrow-side slot that receives the upper halves of pair p
    function automatic int nar_hi(input int layer, input int p);
        case (layer)
            0:       return p;
            1:       return (p / 2) * 4 + (p % 2);
            default: return 2 * p;
        endcase
    endfunction

    // Narrow-side slot that receives the lower halves of pair p
    function automatic int nar_lo(input int layer, input int p);
        case (layer)
            0:       return p + 4;
            1:       return (p / 2) * 4 + (p % 2) + 2;
            default: return 2 * p + 1;
        endcase
    endfunction

endpackage

// File: rtl/bst_shuffle.sv
// One halving layer as pure wiring: either splits fields of a word pair
// (MERGE = 0) or interleaves two half-field streams back (MERGE = 1).
module bst_shuffle #(
    parameter int W     = 32,
    parameter int LAYER = 0,
    parameter bit MERGE = 1'b0
) (
    input  logic [7:0][W-1:0] din,
    output logic [7:0][W-1:0] dout
);
    import bst_pkg::*;

    localparam int F  = layer_field(LAYER);
    localparam int H  = F / 2;
    localparam int NF = (2 * W) / F;

    for (genvar p = 0; p < N_PAIRS; p++) begin : g_pair
        localparam int HI = nar_hi(LAYER, p);
        localparam int LO = nar_lo(LAYER, p);
        logic [2*W-1:0] cat;

        if (MERGE == 1'b0) begin : g_pack
            assign cat = {din[2*p], din[2*p+1]};
            for (genvar i = 0; i < NF; i++) begin : g_fld
                assign dout[HI][W-1-i*H -: H] = cat[2*W-1-i*F -: H];
                assign dout[LO][W-1-i*H -: H] = cat[2*W-1-i*F-H -: H];
            end
        end else begin : g_merge
            for (genvar i = 0; i < NF; i++) begin : g_fld
                assign cat[2*W-1-i*F -: H]   = din[HI][W-1-i*H -: H];
                assign cat[2*W-1-i*F-H -: H] = din[LO][W-1-i*H -: H];
            end
            assign dout[2*p]   = cat[2*W-1:W];
            assign dout[2*p+1] = cat[W-1:0];
        end
    end

endmodule

// File: rtl/bst_stage.sv
// One pipeline stage: forward uses layer STAGE, inverse the mirrored layer.
module bst_stage #(
    parameter int W     = 32,
    parameter int STAGE = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_vld,
    input  logic             in_inv,
    input  logic [7:0][W-1:0] in_dat,
    output logic             out_vld,
    output logic             out_inv,
    output logic [7:0][W-1:0] out_dat
);
    import bst_pkg::*;

    localparam int INV_LAYER = N_LAYERS - 1 - STAGE;

    typedef struct packed {
        logic             vld;
        logic             inv;
        logic [7:0][W-1:0] dat;
    } stg_t;

    stg_t stg_d, stg_q;
    logic [7:0][W-1:0] fwd_res;
    logic [7:0][W-1:0] inv_res;

    bst_shuffle #(.W(W), .LAYER(STAGE), .MERGE(1'b0)) u_fwd (
        .din  (in_dat),
        .dout (fwd_res)
    );

    bst_shuffle #(.W(W), .LAYER(INV_LAYER), .MERGE(1'b1)) u_inv (
        .din  (in_dat),
        .dout (inv_res)
    );

    always_comb begin
        stg_d     = stg_q;
        stg_d.vld = in_vld;
        if (in_vld) begin
            stg_d.inv = in_inv;
            stg_d.dat = in_inv ? inv_res : fwd_res;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg_q <= '0;
        end else begin
            stg_q <= stg_d;
        end
    end

    assign out_vld = stg_q.vld;
    assign out_inv = stg_q.inv;
    assign out_dat = stg_q.dat;

endmodule

// File: rtl/bst_transpose.sv
module bst_transpose #(
    parameter int W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_inv,
    input  logic [7:0][W-1:0] in_words,
    output logic             out_valid,
    output logic [7:0][W-1:0] out_words
);
    import bst_pkg::*;

    logic [N_LAYERS:0]  vld_c;
    logic [N_LAYERS:0]  inv_c;
    logic [7:0][W-1:0]  dat_c [N_LAYERS+1];
    logic [N_LAYERS-1:0] stg_vld;
    logic [N_LAYERS-1:0] stg_inv;

    assign vld_c[0] = in_valid;
    assign inv_c[0] = in_inv;
    assign dat_c[0] = in_words;

    for (genvar s = 0; s < N_LAYERS; s++) begin : g_stage
        bst_stage #(.W(W), .STAGE(s)) u_stg (
            .clk     (clk),
            .rst_n   (rst_n),
            .in_vld  (vld_c[s]),
            .in_inv  (inv_c[s]),
            .in_dat  (dat_c[s]),
            .out_vld (vld_c[s+1]),
            .out_inv (inv_c[s+1]),
            .out_dat (dat_c[s+1])
        );
        assign stg_vld[s] = vld_c[s+1];
        assign stg_inv[s] = inv_c[s+1];
    end

    assign out_valid = vld_c[N_LAYERS];
    assign out_words = dat_c[N_LAYERS];

endmodule

// File: rtl/bst_transpose_chk.sv
module bst_transpose_chk #(
    parameter int W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_inv,
    input logic             out_valid,
    input logic [7:0][W-1:0] out_words,
    input logic [2:0]       stg_vld,
    input logic [2:0]       stg_inv
);

    // R1: reset clears the result
    always @(negedge clk) begin
        if (rst_n === 1'b0) begin
            a_reset_clear_r1: assert (out_valid == 1'b0 && out_words == '0)
                else $error("reset state not clear");
        end
    end

    // R2: a group enters the first register one cycle after in_valid
    p_enter_r2: assert property (@(posedge clk) disable iff (!rst_n)
        stg_vld[0] == $past(in_valid));

    // R2: valid advances one register per cycle
    p_chain_a_r2: assert property (@(posedge clk) disable iff (!rst_n)
        stg_vld[0] |=> stg_vld[1]);

    p_chain_b_r2: assert property (@(posedge clk) disable iff (!rst_n)
        stg_vld[1] |=> out_valid);

    // R5: direction tag stays with its group
    p_dir_enter_r5: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> stg_inv[0] == $past(in_inv));

    p_dir_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        stg_vld[0] |=> stg_inv[1] == $past(stg_inv[0]));

    // R7: output words hold while nothing completes
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_words));

endmodule

bind bst_transpose bst_transpose_chk #(.W(W)) u_chk (.*);

// File: tb/sim_bst_transpose.sv
`timescale 1ns/1ps
module sim_bst_transpose;

    localparam int W  = 16;
    localparam int NB = W / 8;
    localparam int NG = 512;

    typedef logic [7:0][W-1:0] grp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic in_inv = 1'b0;
    grp_t in_words = '0;
    logic out_valid;
    grp_t out_words;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    grp_t  g_dat [NG];
    logic  g_vld [NG];
    logic  g_inv [NG];
    grp_t  e_dat [NG];
    string g_req [NG];
    grp_t  cap   [NG];
    grp_t  rt_src [64];
    grp_t  rt_fwd [64];
    grp_t  last_out;

    always #2 clk = ~clk;

    bst_transpose #(.W(W)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_inv    (in_inv),
        .in_words  (in_words),
        .out_valid (out_valid),
        .out_words (out_words)
    );

    // Reference per R3: stream k bit W-1-j = byte j bit (7-k)
    function automatic grp_t fwd_ref(input grp_t w);
        grp_t s = '0;
        for (int k = 0; k < 8; k++)
            for (int j = 0; j < W; j++)
                s[k][W-1-j] = w[j/NB][W-1-8*(j%NB)-k];
        return s;
    endfunction

    // Reference per R4: inverse of fwd_ref
    function automatic grp_t inv_ref(input grp_t s);
        grp_t w = '0;
        for (int k = 0; k < 8; k++)
            for (int j = 0; j < W; j++)
                w[j/NB][W-1-8*(j%NB)-k] = s[k][W-1-j];
        return w;
    endfunction

    function automatic grp_t rnd_grp();
        grp_t g;
        for (int i = 0; i < 8; i++) g[i] = W'($urandom);
        return g;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input grp_t act, input grp_t exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic finish_sim();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    endtask

    // Streams n groups back to back; checks each three cycles later (R2)
    task automatic run(input int n);
        for (int c = 0; c < n + 3; c++) begin
            @(negedge clk);
            if (c >= 3) begin
                int i = c - 3;
                check(out_valid == g_vld[i], "R2", "out_valid timing",
                      grp_t'(out_valid), grp_t'(g_vld[i]));
                if (g_vld[i]) begin
                    check(out_words == e_dat[i], g_req[i], "result", out_words, e_dat[i]);
                    cap[i]   = out_words;
                    last_out = e_dat[i];
                end else begin
                    check(out_words == last_out, "R7", "idle hold", out_words, last_out);
                end
            end
            if (c < n) begin
                in_valid = g_vld[c];
                in_inv   = g_inv[c];
                in_words = g_dat[c];
            end else begin
                in_valid = 1'b0;
                in_inv   = 1'b0;
                in_words = '0;
            end
        end
    endtask

    function automatic void set_grp(input int i, input logic v, input logic inv,
                                    input grp_t d, input string req);
        g_vld[i] = v;
        g_inv[i] = inv;
        g_dat[i] = d;
        g_req[i] = req;
        e_dat[i] = inv ? inv_ref(d) : fwd_ref(d);
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_sim();
    end

    initial begin
        int n;
        last_out = '0;
        // R1: reset state
        repeat (3) begin
            @(negedge clk);
            check(out_valid == 1'b0 && out_words == '0, "R1", "reset state",
                  out_words, '0);
        end
        rst_n = 1'b1;

        // R3: forward walking one over all 8*W bits, plus zeros and ones
        n = 0;
        for (int b = 0; b < 8 * W; b++) begin
            grp_t d = '0;
            d[b / W][b % W] = 1'b1;
            set_grp(n++, 1'b1, 1'b0, d, "R3");
        end
        set_grp(n++, 1'b1, 1'b0, '0, "R3");
        set_grp(n++, 1'b1, 1'b0, '1, "R3");
        for (int r = 0; r < 64; r++) begin
            rt_src[r] = rnd_grp();
            set_grp(n++, 1'b1, 1'b0, rt_src[r], "R3");
        end
        run(n);
        for (int r = 0; r < 64; r++) rt_fwd[r] = cap[8 * W + 2 + r];

        // R4: inverse walking one and random streams
        n = 0;
        for (int b = 0; b < 8 * W; b++) begin
            grp_t d = '0;
            d[b / W][b % W] = 1'b1;
            set_grp(n++, 1'b1, 1'b1, d, "R4");
        end
        for (int r = 0; r < 64; r++) set_grp(n++, 1'b1, 1'b1, rnd_grp(), "R4");
        run(n);

        // R5 and R7: interleaved directions with idle gaps
        n = 0;
        for (int r = 0; r < 200; r++) begin
            logic v = ($urandom % 4) != 0;
            set_grp(n++, v, logic'($urandom % 2), rnd_grp(), "R5");
        end
        run(n);

        // R6: RTL forward results fed back through the inverse
        n = 0;
        for (int r = 0; r < 64; r++) begin
            set_grp(n, 1'b1, 1'b1, rt_fwd[r], "R6");
            e_dat[n] = rt_src[r];
            n++;
        end
        run(n);

        repeat (2) @(negedge clk);
        finish_sim();
    end

endmodule